// File: doc/BRIEF.md
# UART FIFO Watermark Request Logic

This block sits beside the transmit and receive FIFOs of a serial port and tells the processor when to act. It keeps a running count of the words held in each FIFO. The FIFO storage, the serial shifters and the baud generator are outside the block. Their activity reaches it as single-cycle strobes: a word written into the transmit FIFO, a word moved from the transmit FIFO into the shift register, a word received into the receive FIFO, and a word read out of the receive FIFO. A word that has already gone into the transmit shift register is no longer counted.

Each count is compared with a watermark that software programs. The transmit side raises a space request while its count is at or below the transmit watermark. The receive side sets a sticky data-ready flag once its count reaches the receive watermark. That flag clears only when a read brings the count below the threshold. Each request is enabled per direction and is steered either to an interrupt line or to a DMA request line. Software reaches the watermarks, the counts, the control bits and a status byte through a byte-wide register port. Register reads are combinational and writes take effect at the clock edge. Free transmit space is computed in software as the FIFO depth minus the transmit count.

Top module: `uart_fifo_wm`

## Requirements
- R1: After reset these registers read as follows: control (address 0) reads 0, transmit watermark (address 1) reads 0, transmit count (address 2) reads 0, receive watermark (address 3) reads 1, receive count (address 4) reads 0. All four request outputs are low.
- R2: A push strobe raises a count by one and a pop strobe lowers it by one, both at the next clock edge. A push and a pop in the same cycle leave the count unchanged. On the transmit side the pop strobe is the shift-register load.
- R3: Each count saturates. It never rises above the FIFO depth and never falls below 0.
- R4: Status bit 0 (status is at address 5) is the transmit request. It is high exactly while the transmit count is less than or equal to the transmit watermark.
- R5: Control bit 0 enables the transmit request and control bit 1 selects DMA. With the request enabled, `tx_irq` carries it when bit 1 is 0 and `tx_dma` carries it when bit 1 is 1. The two lines are never high together.
- R6: Status bit 1 is the receive data flag. It sets at the edge where the receive count becomes greater than or equal to the receive watermark. It clears at the edge where a pop leaves the count below the watermark.
- R7: Control bit 4 is the receiver enable. A write to the receive watermark while this bit is 1 is ignored. The same write is accepted while the bit is 0.
- R8: Writing a new receive watermark never clears a receive data flag that is already set. The flag stays set until a pop brings the count below the watermark.
- R9: Control bit 2 enables the receive request and control bit 3 selects DMA. With the request enabled, `rx_irq` carries the receive flag when bit 3 is 0 and `rx_dma` carries it when bit 3 is 1.
- R10: Status bit 2 is high while the transmit watermark is greater than or equal to the FIFO depth. Such a value is out of range.
- R11: With the receive watermark at its reset value of 1, a single received word sets the receive flag.
- R12: Writes to the two count addresses (2 and 4) have no effect on the counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (3) | Register address |
| reg_wdata | input | DW (8) | Register write data |
| reg_rdata | output | DW (8) | Register read data (combinational) |
| tx_push | input | 1 | Word written into the transmit FIFO |
| tx_load | input | 1 | Word moved from the transmit FIFO into the shift register |
| rx_push | input | 1 | Word received into the receive FIFO |
| rx_pop | input | 1 | Word read out of the receive FIFO |
| tx_irq | output | 1 | Transmit request on the interrupt line |
| tx_dma | output | 1 | Transmit request on the DMA line |
| rx_irq | output | 1 | Receive request on the interrupt line |
| rx_dma | output | 1 | Receive request on the DMA line |

## Verification
The bench builds the block with a FIFO depth of 4 rather than the default 8. With that depth, both counts reach their upper saturation point after a few strobes. It also makes a watermark value equal to the depth quick to reach, which is the first out-of-range setting. Within a short run, the transmit watermark is walked across the in-range/out-of-range boundary, and the receive flag is followed through set, hold across a watermark rewrite, and clear, with the count at both of its limits.

// File: rtl/uart_wm_pkg.sv
package uart_wm_pkg;

   // Register addresses; software and the bench rely on these values.
   typedef enum logic [2:0] {
      RA_CTRL  = 3'd0,
      RA_TXWM  = 3'd1,
      RA_TXCNT = 3'd2,
      RA_RXWM  = 3'd3,
      RA_RXCNT = 3'd4,
      RA_STAT  = 3'd5
   } wm_reg_e;

   // Control byte, bits 4..0 (packed: first member is the MSB).
   typedef struct packed {
      logic rx_en;
      logic rx_dma_sel;
      logic rx_ie;
      logic tx_dma_sel;
      logic tx_ie;
   } wm_ctrl_t;

   localparam int CTRL_W = $bits(wm_ctrl_t);

   // Direction indices for the steering array.
   localparam int DIR_TX = 0;
   localparam int DIR_RX = 1;
   localparam int N_DIR  = 2;

endpackage

// File: rtl/wm_level_counter.sv
module wm_level_counter #(
   parameter int DEPTH = 8,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] cnt_d
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   if (DEPTH < 2) begin : g_chk_depth
      $error("wm_level_counter: DEPTH must be at least 2");
   end
   if ((1 << CW) <= DEPTH) begin : g_chk_cw
      $error("wm_level_counter: CW too narrow for DEPTH");
   end

   logic step_up;
   logic step_dn;

   always_comb begin
      step_up = push && !pop && (cnt_q != FULL);
      step_dn = pop && !push && (cnt_q != '0);
      cnt_d   = cnt_q;
      if (step_up) begin
         cnt_d = cnt_q + 1'b1;
      end else if (step_dn) begin
         cnt_d = cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);

   assert_pair_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> $stable(cnt_q));

   assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && cnt_q != FULL) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/wm_regfile.sv
module wm_regfile
   import uart_wm_pkg::*;
#(
   parameter int AW       = 3,
   parameter int DW       = 8,
   parameter int CW       = 4,
   parameter int RXWM_RST = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [CW-1:0] tx_cnt,
   input  logic [CW-1:0] rx_cnt,
   input  logic [2:0]    stat_bits,
   output wm_ctrl_t      ctrl_q,
   output logic [DW-1:0] tx_wm_q,
   output logic [DW-1:0] rx_wm_q,
   output logic [DW-1:0] rdata
);

   if (AW < 3) begin : g_chk_aw
      $error("wm_regfile: AW must be at least 3");
   end
   if (DW < CTRL_W || DW < CW) begin : g_chk_dw
      $error("wm_regfile: DW too narrow");
   end

   logic hit_ctrl;
   logic hit_txwm;
   logic hit_rxwm;
   logic rxwm_open;

   always_comb begin
      hit_ctrl  = wr_en && (addr == AW'(RA_CTRL));
      hit_txwm  = wr_en && (addr == AW'(RA_TXWM));
      hit_rxwm  = wr_en && (addr == AW'(RA_RXWM));
      rxwm_open = !ctrl_q.rx_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         tx_wm_q <= '0;
         rx_wm_q <= DW'(RXWM_RST);
      end else begin
         if (hit_ctrl) begin
            ctrl_q <= wm_ctrl_t'(wdata[CTRL_W-1:0]);
         end
         if (hit_txwm) begin
            tx_wm_q <= wdata;
         end
         if (hit_rxwm && rxwm_open) begin
            rx_wm_q <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == AW'(RA_CTRL)) begin
         rdata = DW'(ctrl_q);
      end else if (addr == AW'(RA_TXWM)) begin
         rdata = tx_wm_q;
      end else if (addr == AW'(RA_TXCNT)) begin
         rdata = DW'(tx_cnt);
      end else if (addr == AW'(RA_RXWM)) begin
         rdata = rx_wm_q;
      end else if (addr == AW'(RA_RXCNT)) begin
         rdata = DW'(rx_cnt);
      end else if (addr == AW'(RA_STAT)) begin
         rdata = DW'(stat_bits);
      end
   end

   assert_rxwm_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(RA_RXWM) && ctrl_q.rx_en) |=> $stable(rx_wm_q));

endmodule

// File: rtl/wm_req_route.sv
module wm_req_route (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic enable,
   input  logic dma_sel,
   output logic irq_line,
   output logic dma_line
);

   always_comb begin
      irq_line = req && enable && !dma_sel;
      dma_line = req && enable && dma_sel;
   end

   assert_one_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_line, dma_line}));

endmodule

// File: rtl/uart_fifo_wm.sv
module uart_fifo_wm
   import uart_wm_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int DW    = 8,
   parameter int AW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [AW-1:0] reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          tx_push,
   input  logic          tx_load,
   input  logic          rx_push,
   input  logic          rx_pop,
   output logic          tx_irq,
   output logic          tx_dma,
   output logic          rx_irq,
   output logic          rx_dma
);

   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH >= (1 << DW)) begin : g_chk_fit
      $error("uart_fifo_wm: DEPTH does not fit a register byte");
   end

   logic [CW-1:0] tx_cnt_q, tx_cnt_d;
   logic [CW-1:0] rx_cnt_q, rx_cnt_d;
   wm_ctrl_t      ctrl;
   logic [DW-1:0] tx_wm;
   logic [DW-1:0] rx_wm;
   logic          tx_req;
   logic          txwm_bad;
   logic          rx_flag_q;
   logic          rx_hit;

   wm_level_counter #(.DEPTH(DEPTH), .CW(CW)) u_tx_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_push),
      .pop   (tx_load),
      .cnt_q (tx_cnt_q),
      .cnt_d (tx_cnt_d)
   );

   wm_level_counter #(.DEPTH(DEPTH), .CW(CW)) u_rx_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_push),
      .pop   (rx_pop),
      .cnt_q (rx_cnt_q),
      .cnt_d (rx_cnt_d)
   );

   // Transmit side: level request from the registered count.
   always_comb begin
      tx_req   = DW'(tx_cnt_q) <= tx_wm;
      txwm_bad = tx_wm >= DW'(DEPTH);
      rx_hit   = DW'(rx_cnt_d) >= rx_wm;
   end

   // Receive side: sticky flag, cleared only by a read that drops below.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_flag_q <= 1'b0;
      end else if (rx_hit) begin
         rx_flag_q <= 1'b1;
      end else if (rx_pop) begin
         rx_flag_q <= 1'b0;
      end
   end

   wm_regfile #(.AW(AW), .DW(DW), .CW(CW), .RXWM_RST(1)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_we),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .tx_cnt    (tx_cnt_q),
      .rx_cnt    (rx_cnt_q),
      .stat_bits ({txwm_bad, rx_flag_q, tx_req}),
      .ctrl_q    (ctrl),
      .tx_wm_q   (tx_wm),
      .rx_wm_q   (rx_wm),
      .rdata     (reg_rdata)
   );

   logic [N_DIR-1:0] dir_req, dir_en, dir_sel, dir_irq, dir_dma;

   always_comb begin
      dir_req[DIR_TX] = tx_req;
      dir_en [DIR_TX] = ctrl.tx_ie;
      dir_sel[DIR_TX] = ctrl.tx_dma_sel;
      dir_req[DIR_RX] = rx_flag_q;
      dir_en [DIR_RX] = ctrl.rx_ie;
      dir_sel[DIR_RX] = ctrl.rx_dma_sel;
   end

   for (genvar d = 0; d < N_DIR; d++) begin : g_route
      wm_req_route u_route (
         .clk      (clk),
         .rst_n    (rst_n),
         .req      (dir_req[d]),
         .enable   (dir_en[d]),
         .dma_sel  (dir_sel[d]),
         .irq_line (dir_irq[d]),
         .dma_line (dir_dma[d])
      );
   end

   always_comb begin
      tx_irq = dir_irq[DIR_TX];
      tx_dma = dir_dma[DIR_TX];
      rx_irq = dir_irq[DIR_RX];
      rx_dma = dir_dma[DIR_RX];
   end

   assert_rx_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flag_q && !rx_pop) |=> rx_flag_q);

   assert_tx_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_irq || tx_dma) |-> (DW'(tx_cnt_q) <= tx_wm));

   assert_rx_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_flag_q) |-> $past(rx_pop));

endmodule

// File: tb/test_uart_fifo_wm.sv
module test_uart_fifo_wm;

   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       tx_push = 1'b0, tx_load = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
   logic       tx_irq, tx_dma, rx_irq, rx_dma;

   always #10 clk = ~clk;  // 50 MHz

   uart_fifo_wm #(.DEPTH(DEPTH), .DW(8), .AW(3)) i_uart_fifo_wm (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_push(tx_push), .tx_load(tx_load), .rx_push(rx_push), .rx_pop(rx_pop),
      .tx_irq(tx_irq), .tx_dma(tx_dma), .rx_irq(rx_irq), .rx_dma(rx_dma)
   );

   typedef struct {
      bit         is_out;
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t sb[$];
   logic  probe = 1'b0;
   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   // Monitor: compares in the low phase of the clock.
   always @(negedge clk) begin
      if (probe && sb.size() > 0) begin
         item_t      it;
         logic [7:0] act;
         it  = sb.pop_front();
         act = it.is_out ? {4'b0, rx_dma, rx_irq, tx_dma, tx_irq} : reg_rdata;
         n_chk++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(posedge clk); #1 reg_we = 1'b0;
   endtask

   task automatic strobe(input logic tp, input logic tl, input logic rp, input logic ro);
      tx_push = tp; tx_load = tl; rx_push = rp; rx_pop = ro;
      @(posedge clk); #1;
      tx_push = 1'b0; tx_load = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
   endtask

   task automatic chk_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
      item_t it;
      it.is_out = 1'b0; it.exp = e; it.tag = tag;
      reg_addr = a;
      sb.push_back(it);
      probe = 1'b1;
      @(posedge clk); #1 probe = 1'b0;
   endtask

   // Outputs packed as {rx_dma, rx_irq, tx_dma, tx_irq}.
   task automatic chk_out(input logic [3:0] e, input string tag);
      item_t it;
      it.is_out = 1'b1; it.exp = {4'b0, e}; it.tag = tag;
      sb.push_back(it);
      probe = 1'b1;
      @(posedge clk); #1 probe = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset values
      chk_reg(3'd0, 8'h00, "R1 ctrl");
      chk_reg(3'd1, 8'h00, "R1 txwm");
      chk_reg(3'd2, 8'h00, "R1 txcnt");
      chk_reg(3'd3, 8'h01, "R1 rxwm");
      chk_reg(3'd4, 8'h00, "R1 rxcnt");
      chk_reg(3'd5, 8'h01, "R4 status at reset");
      chk_out(4'b0000, "R1 outputs");

      // R5 transmit steering
      wr(3'd0, 8'h01);
      chk_out(4'b0001, "R5 tx irq");
      wr(3'd0, 8'h03);
      chk_out(4'b0010, "R5 tx dma");

      // R2 R3 R4 transmit count and level
      wr(3'd1, 8'h02);
      repeat (3) strobe(1, 0, 0, 0);
      chk_reg(3'd2, 8'h03, "R2 txcnt after 3 pushes");
      chk_out(4'b0000, "R4 above watermark");
      chk_reg(3'd5, 8'h00, "R4 status above");
      repeat (2) strobe(1, 0, 0, 0);
      chk_reg(3'd2, 8'h04, "R3 txcnt top saturation");
      strobe(0, 1, 0, 0);
      chk_reg(3'd2, 8'h03, "R2 load excludes shifted word");
      strobe(0, 1, 0, 0);
      chk_out(4'b0010, "R4 at watermark");
      strobe(1, 1, 0, 0);
      chk_reg(3'd2, 8'h02, "R2 push and load together");
      repeat (3) strobe(0, 1, 0, 0);
      chk_reg(3'd2, 8'h00, "R3 txcnt bottom saturation");

      // R10 range flag
      wr(3'd1, 8'h04);
      chk_reg(3'd5, 8'h05, "R10 watermark equals depth");
      wr(3'd1, 8'h03);
      chk_reg(3'd5, 8'h01, "R10 watermark in range");

      // R12 count registers read only
      wr(3'd2, 8'h07);
      chk_reg(3'd2, 8'h00, "R12 txcnt write ignored");
      wr(3'd4, 8'h05);
      chk_reg(3'd4, 8'h00, "R12 rxcnt write ignored");

      // R11 single word with reset watermark
      wr(3'd0, 8'h04);
      chk_out(4'b0000, "R9 rx idle");
      strobe(0, 0, 1, 0);
      chk_out(4'b0100, "R11 one word raises rx irq");
      chk_reg(3'd5, 8'h03, "R11 status flag");
      strobe(0, 0, 0, 1);
      chk_out(4'b0000, "R6 read clears flag");

      // R6 threshold of 3
      wr(3'd3, 8'h03);
      repeat (2) strobe(0, 0, 1, 0);
      chk_out(4'b0000, "R6 below threshold");
      strobe(0, 0, 1, 0);
      chk_out(4'b0100, "R6 reaches threshold");
      repeat (2) strobe(0, 0, 1, 0);
      chk_reg(3'd4, 8'h04, "R3 rxcnt top saturation");
      strobe(0, 0, 0, 1);
      chk_out(4'b0100, "R6 still at threshold");
      strobe(0, 0, 0, 1);
      chk_out(4'b0000, "R6 dropped below");
      repeat (3) strobe(0, 0, 0, 1);
      chk_reg(3'd4, 8'h00, "R3 rxcnt bottom saturation");

      // R8 watermark rewrite keeps flag
      wr(3'd3, 8'h01);
      strobe(0, 0, 1, 0);
      chk_out(4'b0100, "R8 flag set");
      wr(3'd3, 8'h04);
      chk_reg(3'd3, 8'h04, "R8 new watermark taken");
      chk_out(4'b0100, "R8 flag kept after rewrite");
      strobe(0, 0, 0, 1);
      chk_out(4'b0000, "R8 flag cleared by read");

      // R9 receive DMA steering
      wr(3'd0, 8'h0C);
      repeat (4) strobe(0, 0, 1, 0);
      chk_out(4'b1000, "R9 rx dma");

      // R7 receive watermark lock
      wr(3'd0, 8'h1C);
      wr(3'd3, 8'h02);
      chk_reg(3'd3, 8'h04, "R7 write ignored while enabled");
      chk_out(4'b1000, "R7 request unchanged");
      wr(3'd0, 8'h0C);
      wr(3'd3, 8'h02);
      chk_reg(3'd3, 8'h02, "R7 write accepted while disabled");

      done = 1'b1;
      repeat (2) @(posedge clk);
      finish_run();
   end

endmodule